// File: doc/BRIEF.md
# Configuration Space Access Port

This block gives a host a two-register window into configuration space. Software first writes an address word that holds an enable flag, a bus number, a device/function number and a register offset. It then reads or writes a data word. Each data access becomes one configuration request, carrying its byte-lane mask, to a downstream target.

Requests for bus zero go straight to the local target array, addressed by device/function and offset. Locally the request is only issued when the slot-population bitmap marks that device/function as present. Requests for any other bus go out on a forwarding port that every bridge sees. The bridges' read results are folded together with a bitwise AND. Any read that no target serves comes back as all ones.

Top module: `cfg_access_port`

## Requirements
- R1: After reset the address word is zero (disabled), no downstream request is raised, and no read response is pending.
- R2: A host write with selector 0 updates the address word only in byte lanes whose enable bit is set (lane k covers bits 8k+7:8k). A host read with selector 0 returns the stored address word.
- R3: While address bit 31 is clear, a data read (selector 1) returns 0xFFFFFFFF and a data write raises no downstream request.
- R4: The bus number is address bits 23:16, the device/function number is bits 15:8, and the register offset is bits 7:2 with bits 1:0 forced to zero.
- R5: An enabled data access to bus 0 whose slot bit is set raises the local request with local address (devfn << 12) | offset, and a read returns the local read data.
- R6: An enabled data access to bus 0 whose slot bit is clear raises no request, and a read returns 0xFFFFFFFF.
- R7: An enabled data access to a bus other than 0 raises only the bridge request, carrying bus, devfn and offset. The local request stays low.
- R8: A bridge read returns the bitwise AND of every bridge's read data.
- R9: The byte-lane mask and write data reach the selected target unchanged, for both reads and writes.
- R10: Every host read gets exactly one response, one cycle after the request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address word, 1 = data word |
| host_be | input | 4 | Byte-lane enables |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | Read response valid |
| host_rdata | output | 32 | Read response data |
| slot_present | input | 256 | Bit n set = local device/function n is populated |
| loc_req | output | 1 | Local target request |
| loc_we | output | 1 | Local write flag |
| loc_addr | output | 20 | Local address (devfn << 12) \| offset |
| loc_be | output | 4 | Local byte-lane mask |
| loc_wdata | output | 32 | Local write data |
| loc_rdata | input | 32 | Local read data, same cycle as request |
| brg_req | output | 1 | Forwarded request to bridges |
| brg_we | output | 1 | Forwarded write flag |
| brg_bus | output | 8 | Forwarded bus number |
| brg_devfn | output | 8 | Forwarded device/function |
| brg_off | output | 8 | Forwarded dword-aligned offset |
| brg_be | output | 4 | Forwarded byte-lane mask |
| brg_wdata | output | 32 | Forwarded write data |
| brg_rdata | input | 64 | Read data of each bridge, 32 bits each, bridge 0 in the low word |

## Verification
A corrupted address word shows at once. The next data access goes to the wrong slot, the wrong bus or the wrong port, and the downstream strobes expose it in the same cycle the access is made. A read of selector 0 exposes it in the following cycle. A wrong routing decision shows up either as a request raised for an empty slot or a disabled window, or as a missing all-ones default one cycle later. A fault in the merge shows as a single wrong bit in the next bridge read response. A response register that is stuck or shifted in time shows up as a missing, extra or late valid pulse one cycle after a read.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [7:0] devfn;
        logic [7:0] off;
    } cfg_fields_t;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_LOCAL  = 2'd1,
        TGT_BRIDGE = 2'd2
    } cfg_tgt_e;

    typedef struct packed {
        logic [31:0] addr;
        logic        rvalid;
        logic [31:0] rdata;
    } cfg_state_t;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_port_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    output cfg_fields_t   fields
);
    localparam int unsigned EN_BIT = AW - 1;

    logic unused_bits;
    assign unused_bits = ^{addr[EN_BIT-1:24], addr[1:0]};

    always_comb begin
        fields.en    = addr[EN_BIT];
        fields.bus   = addr[23:16];
        fields.devfn = addr[15:8];
        fields.off   = {addr[7:2], 2'b00};
    end
endmodule

// File: rtl/cfg_route.sv
module cfg_route
    import cfg_port_pkg::*;
#(
    parameter int unsigned SLOTS = 256
) (
    input  logic             access,
    input  cfg_fields_t      fields,
    input  logic [SLOTS-1:0] present,
    output cfg_tgt_e         tgt
);
    always_comb begin
        tgt = TGT_NONE;
        if (access && fields.en) begin
            if (fields.bus == 8'h00) begin
                if (present[fields.devfn]) tgt = TGT_LOCAL;
            end else begin
                tgt = TGT_BRIDGE;
            end
        end
    end
endmodule

// File: rtl/cfg_bridge_merge.sv
module cfg_bridge_merge #(
    parameter int unsigned NB = 2,
    parameter int unsigned DW = 32
) (
    input  logic [NB*DW-1:0] in_data,
    output logic [DW-1:0]    merged
);
    logic [NB:0][DW-1:0] acc;
    assign acc[0] = '1;

    for (genvar i = 0; i < NB; i++) begin : g_and
        assign acc[i+1] = acc[i] & in_data[i*DW +: DW];
    end

    assign merged = acc[NB];
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
    import cfg_port_pkg::*;
#(
    parameter int unsigned NUM_BRIDGES = 2,
    parameter int unsigned DW          = 32,
    parameter int unsigned SLOTS       = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_req,
    input  logic                      host_we,
    input  logic                      host_sel,
    input  logic [DW/8-1:0]           host_be,
    input  logic [DW-1:0]             host_wdata,
    output logic                      host_rvalid,
    output logic [DW-1:0]             host_rdata,
    input  logic [SLOTS-1:0]          slot_present,
    output logic                      loc_req,
    output logic                      loc_we,
    output logic [19:0]               loc_addr,
    output logic [DW/8-1:0]           loc_be,
    output logic [DW-1:0]             loc_wdata,
    input  logic [DW-1:0]             loc_rdata,
    output logic                      brg_req,
    output logic                      brg_we,
    output logic [7:0]                brg_bus,
    output logic [7:0]                brg_devfn,
    output logic [7:0]                brg_off,
    output logic [DW/8-1:0]           brg_be,
    output logic [DW-1:0]             brg_wdata,
    input  logic [NUM_BRIDGES*DW-1:0] brg_rdata
);
    localparam int unsigned LANES = DW / 8;

    cfg_state_t  st_q, st_d;
    cfg_fields_t fld;
    cfg_tgt_e    tgt;
    logic [DW-1:0] brg_merged;
    logic data_acc;

    assign data_acc = host_req && host_sel;

    cfg_addr_decode #(.AW(DW)) u_dec (
        .addr   (st_q.addr),
        .fields (fld)
    );

    cfg_route #(.SLOTS(SLOTS)) u_route (
        .access  (data_acc),
        .fields  (fld),
        .present (slot_present),
        .tgt     (tgt)
    );

    cfg_bridge_merge #(.NB(NUM_BRIDGES), .DW(DW)) u_merge (
        .in_data (brg_rdata),
        .merged  (brg_merged)
    );

    always_comb begin
        loc_req   = (tgt == TGT_LOCAL);
        loc_we    = host_we;
        loc_addr  = {fld.devfn, 4'h0, fld.off};
        loc_be    = host_be;
        loc_wdata = host_wdata;
        brg_req   = (tgt == TGT_BRIDGE);
        brg_we    = host_we;
        brg_bus   = fld.bus;
        brg_devfn = fld.devfn;
        brg_off   = fld.off;
        brg_be    = host_be;
        brg_wdata = host_wdata;
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = host_req && !host_we;
        if (host_req && !host_sel && host_we) begin
            for (int k = 0; k < LANES; k++) begin
                if (host_be[k]) st_d.addr[8*k +: 8] = host_wdata[8*k +: 8];
            end
        end
        if (host_req && !host_we) begin
            if (!host_sel) begin
                st_d.rdata = st_q.addr;
            end else begin
                unique case (tgt)
                    TGT_LOCAL:  st_d.rdata = loc_rdata;
                    TGT_BRIDGE: st_d.rdata = brg_merged;
                    default:    st_d.rdata = '1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, rvalid: 1'b0, rdata: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rvalid = st_q.rvalid;
    assign host_rdata  = st_q.rdata;

    p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_req && brg_req));
    p_bus0_not_forwarded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brg_req |-> (brg_bus != 8'h00));
    p_empty_slot_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req |-> slot_present[loc_addr[19:12]]);
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.addr[DW-1] |-> !(loc_req || brg_req));
    p_read_response_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we) |=> host_rvalid);
    p_write_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && !host_we) |=> !host_rvalid);
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && host_we && !host_sel) |=> $stable(st_q.addr));
    p_aligned_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req || brg_req) |-> (loc_addr[1:0] == 2'b00 && brg_off[1:0] == 2'b00));
endmodule

// File: tb/cfg_access_port_test.sv
module cfg_access_port_test;
    localparam int NB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 0, host_we = 0, host_sel = 0;
    logic [3:0] host_be = 0;
    logic [31:0] host_wdata = 0;
    logic host_rvalid;
    logic [31:0] host_rdata;
    logic [255:0] slot_present;
    logic loc_req, loc_we;
    logic [19:0] loc_addr;
    logic [3:0] loc_be;
    logic [31:0] loc_wdata, loc_rdata;
    logic brg_req, brg_we;
    logic [7:0] brg_bus, brg_devfn, brg_off;
    logic [3:0] brg_be;
    logic [31:0] brg_wdata;
    logic [NB*32-1:0] brg_rdata;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    cfg_access_port uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_sel(host_sel), .host_be(host_be), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .slot_present(slot_present), .loc_req(loc_req), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_be(loc_be), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .brg_req(brg_req), .brg_we(brg_we),
        .brg_bus(brg_bus), .brg_devfn(brg_devfn), .brg_off(brg_off),
        .brg_be(brg_be), .brg_wdata(brg_wdata), .brg_rdata(brg_rdata)
    );

    // Bench target models: local data derived from the address,
    // bridge 0 claims buses 1..0x10, bridge 1 claims 0x08..0x20.
    function automatic logic [31:0] loc_model(input logic [19:0] a);
        return {4'hC, a ^ 20'h5A5A5, 8'h3E};
    endfunction
    function automatic logic [31:0] brg_model(input int i, input logic [7:0] b,
                                              input logic [7:0] d, input logic [7:0] o);
        if (i == 0) return (b >= 8'h01 && b <= 8'h10) ? ({b, d, o, 8'h00} | 32'h0F0F_00FF) : 32'hFFFF_FFFF;
        return (b >= 8'h08 && b <= 8'h20) ? ({o, b, d, 8'hF0} | 32'h00F0_F00F) : 32'hFFFF_FFFF;
    endfunction

    assign loc_rdata = loc_model(loc_addr);
    assign brg_rdata = {brg_model(1, brg_bus, brg_devfn, brg_off),
                        brg_model(0, brg_bus, brg_devfn, brg_off)};

    // snapshot of downstream outputs during the access cycle
    logic s_loc_req, s_loc_we, s_brg_req, s_brg_we;
    logic [19:0] s_loc_addr;
    logic [3:0] s_loc_be, s_brg_be;
    logic [31:0] s_loc_wdata, s_brg_wdata;
    logic [7:0] s_bus, s_devfn, s_off;
    logic r_valid;
    logic [31:0] r_data;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic sel, input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        host_req = 1; host_we = we; host_sel = sel; host_be = be; host_wdata = wd;
        #1;
        s_loc_req = loc_req; s_loc_we = loc_we; s_loc_addr = loc_addr; s_loc_be = loc_be;
        s_loc_wdata = loc_wdata; s_brg_req = brg_req; s_brg_we = brg_we; s_brg_be = brg_be;
        s_brg_wdata = brg_wdata; s_bus = brg_bus; s_devfn = brg_devfn; s_off = brg_off;
        @(negedge clk);
        r_valid = host_rvalid; r_data = host_rdata;
        host_req = 0; host_we = 0; host_sel = 0; host_be = 0; host_wdata = 0;
    endtask

    task automatic set_addr(input logic [31:0] a);
        access(1'b1, 1'b0, 4'hF, a);
    endtask

    task automatic t_reset;
        check("R1 loc_req idle", {31'd0, loc_req}, 32'd0);
        check("R1 brg_req idle", {31'd0, brg_req}, 32'd0);
        check("R1 rvalid idle", {31'd0, host_rvalid}, 32'd0);
        access(1'b0, 1'b0, 4'hF, 0);
        check("R1 address word zero", r_data, 32'h0);
    endtask

    task automatic t_addr_lanes;
        set_addr(32'hFFFF_FFFF);
        check("R10 no response to write", {31'd0, r_valid}, 32'd0);
        access(1'b1, 1'b0, 4'b0101, 32'h1234_5678);
        access(1'b0, 1'b0, 4'hF, 0);
        check("R2 lane-masked address write", r_data, 32'hFF34_FF78);
        check("R10 read response valid", {31'd0, r_valid}, 32'd1);
    endtask

    task automatic t_disabled;
        set_addr(32'h0000_0810);
        access(1'b0, 1'b1, 4'hF, 0);
        check("R3 disabled read all ones", r_data, 32'hFFFF_FFFF);
        check("R3 disabled read no request", {30'd0, s_loc_req, s_brg_req}, 32'd0);
        access(1'b1, 1'b1, 4'hF, 32'hDEAD_BEEF);
        check("R3 disabled write dropped", {30'd0, s_loc_req, s_brg_req}, 32'd0);
    endtask

    task automatic t_local;
        set_addr(32'h8000_1A37); // bus 0, devfn 0x1A, offset 0x34 (bits 1:0 dropped)
        access(1'b0, 1'b1, 4'b1001, 0);
        check("R5 local request", {31'd0, s_loc_req}, 32'd1);
        check("R7 bridge idle on bus 0", {31'd0, s_brg_req}, 32'd0);
        check("R4 local address", {12'd0, s_loc_addr}, 32'h1A034);
        check("R9 read byte mask", {28'd0, s_loc_be}, 32'h9);
        check("R5 local read data", r_data, loc_model(20'h1A034));
        access(1'b1, 1'b1, 4'b0110, 32'hCAFE_F00D);
        check("R9 local write flag", {31'd0, s_loc_we}, 32'd1);
        check("R9 local write data", s_loc_wdata, 32'hCAFE_F00D);
        check("R9 write byte mask", {28'd0, s_loc_be}, 32'h6);
    endtask

    task automatic t_empty_slot;
        set_addr(32'h8000_2B40); // devfn 0x2B not populated
        access(1'b0, 1'b1, 4'hF, 0);
        check("R6 empty slot no request", {30'd0, s_loc_req, s_brg_req}, 32'd0);
        check("R6 empty slot all ones", r_data, 32'hFFFF_FFFF);
    endtask

    task automatic t_bridge(input logic [7:0] bus);
        logic [31:0] exp;
        set_addr({8'h80, bus, 8'h21, 8'h0E});
        access(1'b0, 1'b1, 4'b0011, 0);
        exp = brg_model(0, bus, 8'h21, 8'h0C) & brg_model(1, bus, 8'h21, 8'h0C);
        check("R7 bridge request", {30'd0, s_loc_req, s_brg_req}, 32'd1);
        check("R4 forwarded fields", {8'd0, s_bus, s_devfn, s_off}, {8'd0, bus, 8'h21, 8'h0C});
        check("R8 merged bridge read", r_data, exp);
        check("R9 bridge byte mask", {28'd0, s_brg_be}, 32'h3);
    endtask

    task automatic t_bridge_write;
        set_addr(32'h8005_0004);
        access(1'b1, 1'b1, 4'b1100, 32'h0BAD_CAFE);
        check("R7 bridge write request", {30'd0, s_loc_req, s_brg_req}, 32'd1);
        check("R9 bridge write data", s_brg_wdata, 32'h0BAD_CAFE);
        check("R9 bridge write flag", {31'd0, s_brg_we}, 32'd1);
    endtask

    initial begin
        slot_present = '0;
        slot_present[8'h1A] = 1'b1;
        slot_present[8'h08] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr_lanes();
        t_disabled();
        t_local();
        t_empty_slot();
        t_bridge(8'h03);  // only bridge 0 claims
        t_bridge(8'h0C);  // both claim: AND
        t_bridge(8'h40);  // none claims: all ones
        t_bridge_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule